// File: doc/BRIEF.md
# Chip-Select Bus Cycle Terminator

This block decides when an external bus cycle is finished for a small set of programmable chip selects. Each chip select has an option entry with a 5-bit wait-state code and a 2-bit memory-mode code. A cycle begins on a one-clock start request. The request carries the decoded chip-select index, the direction and the kind of target: an external device, an on-chip peripheral or on-chip SRAM. The block holds `busy_o` high while the cycle runs. It drives an active-low write strobe and pulses `done_o` for one clock when the cycle ends.

There are three ways a cycle can end. The first is an internal countdown of wait states. The second is an external active-low acknowledge pin, which is synchronised and edge-qualified, so a level held low from an earlier cycle cannot end a new one. The third is a done signal from an SDRAM controller. The wait-state code 31 selects acknowledge mode. A chip select in SDRAM mode also carries the code 31, but it waits only for the controller's done signal and ignores the pin.

Top module: `cs_cycle_term`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), `busy_o` and `done_o` are 0 and `we_n_o` is 1. Every option entry reads back as mode 0 with zero wait states, so a write to any chip select then takes one active cycle with the strobe low.
- R2: An external cycle to a chip select with wait-state code W from 0 to 30, in mode 0, 1 or 3, keeps `busy_o` high for exactly W+1 clocks. `done_o` is high in the clock after that. The acknowledge pin has no effect on such a cycle.
- R3: An external cycle to a chip select with code 31 in mode 0 or 1 ends only on the acknowledge pin. If the pin has been high, driving it low just after clock edge k makes `done_o` high just after edge k+3: two synchroniser stages and one decision edge.
- R4: If the acknowledge pin is still low when a cycle is accepted, that cycle does not end until the pin has been seen high and then low again.
- R5: An external cycle to a chip select in mode 2 (SDRAM) ends in the clock after `sd_done_i` is sampled high, and never before. The acknowledge pin is ignored.
- R6: For an external write, `we_n_o` is low during the cycle only in mode 0 or 1. In mode 2 and mode 3, and for every read, it stays high.
- R7: On-chip cycles (`start_tgt_i` 1 = peripheral, 2 or 3 = SRAM) take one active clock and ignore the option entry. A peripheral write drives `we_n_o` low. An on-chip SRAM write keeps it high.
- R8: Only one cycle runs at a time. A start request sampled while `busy_o` is high is dropped and does not start a later cycle.
- R9: `done_o` is high for exactly one clock per cycle, and `we_n_o` is high in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we_i | input | 1 | Write enable for one option entry |
| cfg_idx_i | input | 2 | Option entry to write |
| cfg_ws_i | input | 5 | Wait-state code (31 = acknowledge/SDRAM) |
| cfg_mode_i | input | 2 | Memory mode: 0/1 async SRAM/ROM, 2 SDRAM, 3 strobeless device |
| start_i | input | 1 | Cycle start request, sampled when not busy |
| start_cs_i | input | 2 | Decoded chip-select index |
| start_wr_i | input | 1 | 1 = write, 0 = read |
| start_tgt_i | input | 2 | 0 external, 1 on-chip peripheral, 2/3 on-chip SRAM |
| ta_n_i | input | 1 | External transfer acknowledge, active low, asynchronous |
| sd_done_i | input | 1 | Cycle-complete signal from the SDRAM controller |
| busy_o | output | 1 | A cycle is in progress |
| done_o | output | 1 | One-clock pulse when a cycle ends |
| we_n_o | output | 1 | Active-low write strobe |

## Verification
The assertions assume that the start, configuration and SDRAM-done inputs are synchronous to `clk`. Only `ta_n_i` may change at any time, because it passes through the synchroniser. They also assume that `sd_done_i` means "finish now" whenever an SDRAM-mode cycle is running. The bench changes every input on the falling clock edge. It raises `sd_done_i` only inside SDRAM-mode cycles, and it moves the acknowledge pin only between whole clocks, so the latency of the synchroniser can be counted exactly.

// File: rtl/cs_term_pkg.sv
// Shared types for the chip-select cycle terminator.
// Assumes: the wait-state code width is fixed at 5 bits, and the all-ones code selects
// the external acknowledge, or SDRAM termination when the mode is SDRAM.
package cs_term_pkg;
    localparam int WS_W = 5;
    localparam logic [WS_W-1:0] WS_ACK = '1;

    typedef enum logic [1:0] {
        MEM_ASYNC_A  = 2'd0,
        MEM_ASYNC_B  = 2'd1,
        MEM_SDRAM    = 2'd2,
        MEM_NOSTROBE = 2'd3
    } mem_mode_e;

    typedef enum logic [1:0] {
        TGT_EXT    = 2'd0,
        TGT_PERIPH = 2'd1,
        TGT_ISRAM  = 2'd2,
        TGT_RSVD   = 2'd3
    } target_e;

    typedef enum logic [1:0] {
        TERM_COUNT = 2'd0,
        TERM_ACK   = 2'd1,
        TERM_SDRAM = 2'd2
    } term_src_e;

    typedef struct packed {
        logic [WS_W-1:0] ws;
        mem_mode_e       mode;
    } cs_opt_t;
endpackage

// File: rtl/cs_opt_regs.sv
// Option register file: one wait-state/mode entry per chip select.
// Assumes: a single write port and an asynchronous read of the entry selected by rd_idx.
module cs_opt_regs
    import cs_term_pkg::*;
#(
    parameter int N_CS  = 4,
    parameter int IDX_W = (N_CS > 1) ? $clog2(N_CS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  cs_opt_t          wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output cs_opt_t          rd_data
);
    cs_opt_t entry [N_CS];

    for (genvar g = 0; g < N_CS; g++) begin : g_entry
        // Hold one entry; reset gives mode A with zero wait states.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry[g] <= '{ws: '0, mode: MEM_ASYNC_A};
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                entry[g] <= wr_data;
            end
        end
    end

    // Select the entry for the chip select being started.
    always_comb begin
        rd_data = entry[0];
        for (int i = 0; i < N_CS; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = entry[i];
        end
    end
endmodule

// File: rtl/ta_qualifier.sv
// Acknowledge qualifier: synchronises the active-low acknowledge pin and only reports
// a hit after the pin has been seen high during (or just before) the current cycle.
// Assumes: cyc_start is high for the one edge at which a cycle is accepted.
module ta_qualifier #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ta_n_i,
    input  logic cyc_start,
    output logic ack_hit
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   armed_q;
    logic                   ta_s;

    assign ta_s = sync_q[SYNC_STAGES-1];

    // Shift the pin through the synchroniser; the idle level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ta_n_i};
    end

    // Arm on a high level; at cycle start, take the current level so a stale low is not counted.
    always_ff @(posedge clk) begin
        if (!rst_n)         armed_q <= 1'b0;
        else if (cyc_start) armed_q <= ta_s;
        else if (ta_s)      armed_q <= 1'b1;
    end

    assign ack_hit = armed_q && !ta_s;
endmodule

// File: rtl/cycle_ctrl.sv
// Cycle controller: at start, picks the termination source and strobe enable from the
// option entry and the target kind, then counts down, waits for the acknowledge hit,
// or waits for SDRAM done, and ends with a one-clock done pulse.
// Assumes: start_acc is only high when no cycle is active.
module cycle_ctrl
    import cs_term_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_acc,
    input  cs_opt_t         opt,
    input  target_e         tgt,
    input  logic            wr,
    input  logic            ack_hit,
    input  logic            sd_done,
    output logic            active_o,
    output logic            done_o,
    output logic            strobe_o,
    output term_src_e       src_o,
    output logic [WS_W-1:0] cnt_o
);
    logic            active_q, done_q, strobe_q, end_now;
    term_src_e       src_q, src_d;
    logic [WS_W-1:0] cnt_q, cnt_d;
    logic            strobe_d;

    // Decide the termination source, the initial count and the strobe enable for a new cycle.
    always_comb begin
        src_d = TERM_COUNT;
        cnt_d = '0;
        if (tgt == TGT_EXT) begin
            if (opt.mode == MEM_SDRAM)  src_d = TERM_SDRAM;
            else if (opt.ws == WS_ACK)  src_d = TERM_ACK;
            else                        cnt_d = opt.ws;
        end
        strobe_d = wr && ((tgt == TGT_PERIPH) ||
                   ((tgt == TGT_EXT) && ((opt.mode == MEM_ASYNC_A) || (opt.mode == MEM_ASYNC_B))));
    end

    // Decide whether the running cycle ends at this edge.
    always_comb begin
        case (src_q)
            TERM_ACK:   end_now = active_q && ack_hit;
            TERM_SDRAM: end_now = active_q && sd_done;
            default:    end_now = active_q && (cnt_q == '0);
        endcase
    end

    // Cycle state: accept, count down, and end with a done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            done_q   <= 1'b0;
            strobe_q <= 1'b0;
            src_q    <= TERM_COUNT;
            cnt_q    <= '0;
        end else begin
            done_q <= end_now;
            if (start_acc) begin
                active_q <= 1'b1;
                strobe_q <= strobe_d;
                src_q    <= src_d;
                cnt_q    <= cnt_d;
            end else if (end_now) begin
                active_q <= 1'b0;
                strobe_q <= 1'b0;
            end else if (active_q && (src_q == TERM_COUNT)) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign active_o = active_q;
    assign done_o   = done_q;
    assign strobe_o = active_q && strobe_q;
    assign src_o    = src_q;
    assign cnt_o    = cnt_q;
endmodule

// File: rtl/cs_cycle_term.sv
// Top of the chip-select cycle terminator: option registers, acknowledge qualifier
// and cycle controller.
// Assumes: all inputs except ta_n_i are synchronous to clk; one cycle at a time.
module cs_cycle_term
    import cs_term_pkg::*;
#(
    parameter int N_CS  = 4,
    parameter int IDX_W = (N_CS > 1) ? $clog2(N_CS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we_i,
    input  logic [IDX_W-1:0] cfg_idx_i,
    input  logic [WS_W-1:0]  cfg_ws_i,
    input  logic [1:0]       cfg_mode_i,
    input  logic             start_i,
    input  logic [IDX_W-1:0] start_cs_i,
    input  logic             start_wr_i,
    input  logic [1:0]       start_tgt_i,
    input  logic             ta_n_i,
    input  logic             sd_done_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             we_n_o
);
    cs_opt_t         cfg_data, sel_opt;
    logic            start_acc, ack_hit, active, strobe;
    term_src_e       src_w;
    logic [WS_W-1:0] cnt_w;

    assign cfg_data  = '{ws: cfg_ws_i, mode: mem_mode_e'(cfg_mode_i)};
    assign start_acc = start_i && !active;

    cs_opt_regs #(.N_CS(N_CS), .IDX_W(IDX_W)) u_opts (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we_i), .wr_idx(cfg_idx_i),
        .wr_data(cfg_data), .rd_idx(start_cs_i), .rd_data(sel_opt)
    );

    ta_qualifier #(.SYNC_STAGES(2)) u_ta (
        .clk(clk), .rst_n(rst_n), .ta_n_i(ta_n_i),
        .cyc_start(start_acc), .ack_hit(ack_hit)
    );

    cycle_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .opt(sel_opt),
        .tgt(target_e'(start_tgt_i)), .wr(start_wr_i), .ack_hit(ack_hit),
        .sd_done(sd_done_i), .active_o(active), .done_o(done_o),
        .strobe_o(strobe), .src_o(src_w), .cnt_o(cnt_w)
    );

    assign busy_o = active;
    assign we_n_o = !strobe;
endmodule

// File: rtl/cs_cycle_term_checker.sv
// Property checker for the cycle terminator, bound into the top module.
// Assumes: synchronous inputs except the acknowledge pin.
module cs_cycle_term_checker
    import cs_term_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            we_n,
    input logic            sd_done,
    input logic            ack_hit,
    input term_src_e       src,
    input logic [WS_W-1:0] cnt
);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_strobe_off_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> we_n);
    assert_no_done_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
    assert_busy_needs_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    assert_count_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && src == TERM_COUNT && cnt == '0) |=> (done && !busy));
    assert_ack_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && src == TERM_ACK && ack_hit) |=> done);
    assert_ack_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && src == TERM_ACK && !ack_hit) |=> !done);
    assert_sdram_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && src == TERM_SDRAM && sd_done) |=> done);
    assert_sdram_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && src == TERM_SDRAM && !sd_done) |=> !done);
endmodule

bind cs_cycle_term cs_cycle_term_checker u_chk (
    .clk(clk), .rst_n(rst_n), .start(start_i), .busy(busy_o), .done(done_o),
    .we_n(we_n_o), .sd_done(sd_done_i), .ack_hit(ack_hit), .src(src_w), .cnt(cnt_w)
);

// File: tb/cs_cycle_term_bench.sv
module cs_cycle_term_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic [1:0] cfg_idx_i = '0;
    logic [4:0] cfg_ws_i = '0;
    logic [1:0] cfg_mode_i = '0;
    logic       start_i = 1'b0, start_wr_i = 1'b0;
    logic [1:0] start_cs_i = '0, start_tgt_i = '0;
    logic       ta_n_i = 1'b1, sd_done_i = 1'b0;
    logic       busy_o, done_o, we_n_o;

    int n_run = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cs_cycle_term u_cs_cycle_term (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_run();
    end

    // Called at a falling edge; writes one option entry.
    task automatic set_cfg(input int idx, input int ws, input int mode);
        cfg_we_i = 1'b1; cfg_idx_i = 2'(idx); cfg_ws_i = 5'(ws); cfg_mode_i = 2'(mode);
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    // Called at a falling edge; presents a start request for the next rising edge.
    task automatic issue(input int cs, input bit wr, input int tgt);
        start_i = 1'b1; start_cs_i = 2'(cs); start_wr_i = wr; start_tgt_i = 2'(tgt);
    endtask

    // Counts falling edges without done (n); wlow notes a low strobe; on done checks R9.
    task automatic wait_done(input int limit, output int n, output bit wlow);
        n = 0; wlow = 1'b0;
        forever begin
            @(negedge clk);
            start_i = 1'b0;
            if (done_o) break;
            if (!we_n_o) wlow = 1'b1;
            n++;
            if (n == limit) return;
        end
        chk(we_n_o == 1'b1, "R9 strobe high at done", int'(we_n_o), 1);
        @(negedge clk);
        chk(done_o == 1'b0, "R9 done one clock", int'(done_o), 0);
    endtask

    task automatic t_reset();
        chk(busy_o == 0 && done_o == 0, "R1 idle after reset", int'({busy_o, done_o}), 0);
        chk(we_n_o == 1, "R1 strobe high after reset", int'(we_n_o), 1);
        for (int cs = 0; cs < 4; cs++) begin
            int n; bit wl;
            issue(cs, 1'b1, 0);
            wait_done(40, n, wl);
            chk(n == 1, "R1 reset entry zero wait", n, 1);
            chk(wl == 1'b1, "R1 reset entry mode A strobe", int'(wl), 1);
        end
    endtask

    task automatic t_count(input int cs, input int ws, input int mode, input bit ta_low);
        int n; bit wl;
        set_cfg(cs, ws, mode);
        ta_n_i = !ta_low;
        issue(cs, 1'b0, 0);
        wait_done(60, n, wl);
        chk(n == ws + 1, "R2 counted wait states", n, ws + 1);
        ta_n_i = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_ack();
        int n; bit wl;
        set_cfg(1, 31, 0);
        issue(1, 1'b1, 0);
        wait_done(6, n, wl);
        chk(n == 6, "R3 no end without acknowledge", n, 6);
        ta_n_i = 1'b0;
        wait_done(10, n, wl);
        chk(n == 2, "R3 acknowledge latency", n, 2);
        chk(wl == 1'b1, "R6 mode A write strobe", int'(wl), 1);
        ta_n_i = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_ack_stuck();
        int n; bit wl;
        set_cfg(1, 31, 1);
        ta_n_i = 1'b0;
        repeat (4) @(negedge clk);
        issue(1, 1'b0, 0);
        wait_done(8, n, wl);
        chk(n == 8, "R4 stale acknowledge ignored", n, 8);
        ta_n_i = 1'b1;
        wait_done(4, n, wl);
        chk(n == 4, "R4 high level alone does not end", n, 4);
        ta_n_i = 1'b0;
        wait_done(10, n, wl);
        chk(n == 2, "R4 fresh acknowledge ends cycle", n, 2);
        ta_n_i = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_sdram();
        int n; bit wl;
        set_cfg(2, 31, 2);
        issue(2, 1'b1, 0);
        wait_done(4, n, wl);
        ta_n_i = 1'b0;
        wait_done(6, n, wl);
        chk(n == 6, "R5 acknowledge ignored in SDRAM mode", n, 6);
        chk(wl == 1'b0, "R6 no strobe in SDRAM mode", int'(wl), 0);
        sd_done_i = 1'b1;
        wait_done(4, n, wl);
        sd_done_i = 1'b0;
        chk(n == 0, "R5 ends after SDRAM done", n, 0);
        ta_n_i = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_strobe();
        int n; bit wl;
        set_cfg(0, 2, 1);
        issue(0, 1'b1, 0); wait_done(20, n, wl);
        chk(wl == 1'b1, "R6 mode B write strobe", int'(wl), 1);
        issue(0, 1'b0, 0); wait_done(20, n, wl);
        chk(wl == 1'b0, "R6 read has no strobe", int'(wl), 0);
        set_cfg(3, 3, 3);
        issue(3, 1'b1, 0); wait_done(20, n, wl);
        chk(wl == 1'b0, "R6 mode 3 write has no strobe", int'(wl), 0);
        chk(n == 4, "R2 mode 3 counted wait states", n, 4);
    endtask

    task automatic t_onchip();
        int n; bit wl;
        set_cfg(0, 9, 0);
        issue(0, 1'b1, 1); wait_done(20, n, wl);
        chk(n == 1 && wl == 1'b1, "R7 peripheral write one clock, strobe low", n, 1);
        issue(0, 1'b1, 2); wait_done(20, n, wl);
        chk(n == 1 && wl == 1'b0, "R7 on-chip SRAM write, strobe high", n, 1);
    endtask

    task automatic t_busy();
        int n; bit wl;
        set_cfg(0, 6, 0);
        set_cfg(3, 0, 0);
        issue(0, 1'b0, 0);
        @(negedge clk); start_i = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b1, "R8 busy during cycle", int'(busy_o), 1);
        issue(3, 1'b1, 0);
        wait_done(30, n, wl);
        chk(n == 5, "R8 cycle length unchanged by held-off start", n, 5);
        chk(wl == 1'b0, "R8 held-off write did not take effect", int'(wl), 0);
        repeat (3) begin
            chk(busy_o == 1'b0, "R8 dropped start does not run later", int'(busy_o), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count(1, 0, 0, 1'b0);
        t_count(1, 4, 0, 1'b1);
        t_count(2, 30, 1, 1'b1);
        t_ack();
        t_ack_stuck();
        t_sdram();
        t_strobe();
        t_onchip();
        t_busy();
        finish_run();
    end
endmodule